// File: doc/BRIEF.md
# Dirty-Band Update Rectangle Coalescer

This block tracks which parts of a framebuffer have been written and turns that record into a short list of screen regions to redraw. The frame is split into horizontal bands of four display lines. The primary 8-bit pixel plane has one dirty flag per band. When the optional deep-colour layout is built, there are two extra planes, a 24-bit pixel plane and a per-pixel control plane. Each of these is four times wider and has four dirty flags per band. The write-snooping logic outside the block marks flags through a single mark port. A separate invalidate pulse marks every flag at once.

On a scan request the block walks the bands from the top of the frame, one band per clock. It merges runs of adjacent dirty bands into single full-width rectangles and hands each one out over a valid/ready handshake. While a rectangle waits to be accepted, the walk is held. After the last band the block clears the dirty flags over the span from the lowest to the highest dirty band it found. It then pulses a done strobe for one cycle.

Top module: `dirty_band_coalescer`

## Requirements
- R1: After reset, rect_valid and scan_done are low and every dirty flag is clean, so a first scan emits no rectangle.
- R2: Band k covers lines 4k to 4k+3. A rectangle's rect_y is four times the index of the first dirty band of its run.
- R3: A run of n consecutive dirty bands yields exactly one rectangle with rect_h = 4n. The rectangle is emitted when the scan meets the first clean band after the run.
- R4: The scan covers bands 0 to B-1, where B = ceil(cfg_lines/4), capped at NUM_BANDS. A run still open at band B is flushed with rect_h = 4B - rect_y. Bands at or beyond B are not examined.
- R5: Every rectangle spans the full width: rect_w equals the cfg_width value sampled when the scan started, and the horizontal origin is always 0.
- R6: Mark port encoding: mark_plane 0 selects the 8-bit plane (page = band), 1 the 24-bit plane and 2 the control plane (page p belongs to band p/4). Code 3 is ignored.
- R7: When cfg_wide is high at scan start, band k is dirty if its 8-bit flag is set or any of pages 4k to 4k+3 is set in either extra plane. When cfg_wide is low, only the 8-bit flag counts.
- R8: After a scan, the 8-bit flags from the lowest to the highest dirty band seen are cleared. In wide mode, pages 4*lowest to 4*highest+3 of both extra planes are cleared as well. In 8-bit mode the extra planes are left untouched, and flags of bands not examined are kept.
- R9: A scan that finds no dirty band emits no rectangle and clears nothing. Every scan ends with scan_done high for exactly one cycle.
- R10: A one-cycle invalidate pulse sets every flag of every plane, so the next scan redraws the whole active area as one rectangle.
- R11: While rect_valid is high and rect_ready is low, rect_valid, rect_y and rect_h hold steady and the scan does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mark_en | input | 1 | Set one dirty flag this cycle |
| mark_plane | input | 2 | Plane code for the mark (0 8-bit, 1 24-bit, 2 control) |
| mark_page | input | BCNT_W+2 | Page index within the selected plane |
| invalidate | input | 1 | Set every flag of every plane |
| scan_start | input | 1 | Begin a frame scan (ignored while busy) |
| cfg_wide | input | 1 | Deep-colour dirtiness rule for this scan |
| cfg_lines | input | BCNT_W+2 | Active display height in lines |
| cfg_width | input | WIDTH_W | Active display width in pixels |
| rect_valid | output | 1 | Rectangle available |
| rect_ready | input | 1 | Consumer accepts the rectangle |
| rect_y | output | BCNT_W+2 | First line of the rectangle |
| rect_h | output | BCNT_W+2 | Number of lines in the rectangle |
| rect_w | output | WIDTH_W | Rectangle width (full active width) |
| scan_done | output | 1 | One-cycle end-of-scan strobe |

## Verification
The bench builds the block with NUM_BANDS = 8, WIDTH_W = 11 and the deep-colour planes present. With this size a 32-line frame holds every band, and a shortened height can leave tail bands unscanned in a few dozen cycles. It also lets a run reach the last band and be flushed at the end of the scan, and lets both extra planes feed bands in the middle and at the bottom of the frame. A throttled ready pattern exercises the stall path, and mixing 8-bit and wide scans on the same flags makes the plane-selective clearing visible at the ports.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SCAN  = 2'd1,
      ST_HOLD  = 2'd2,
      ST_CLEAR = 2'd3
   } scan_state_e;

   localparam logic [1:0] PL_BASE = 2'd0;
   localparam logic [1:0] PL_DEEP = 2'd1;
   localparam logic [1:0] PL_CTRL = 2'd2;
endpackage

// File: rtl/dbc_dirty_store.sv
module dbc_dirty_store
   import dbc_pkg::*;
#(
   parameter int NUM_BANDS = 192,
   parameter bit HAS_WIDE  = 1'b1,
   localparam int BCNT_W   = $clog2(NUM_BANDS + 1),
   localparam int PAGE_W   = BCNT_W + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mark_en,
   input  logic [1:0]           mark_plane,
   input  logic [PAGE_W-1:0]    mark_page,
   input  logic                 invalidate,
   input  logic                 clr_en,
   input  logic                 clr_wide,
   input  logic [BCNT_W-1:0]    clr_lo,
   input  logic [BCNT_W-1:0]    clr_hi,
   input  logic                 wide_mode,
   output logic [NUM_BANDS-1:0] band_dirty
);
   logic [NUM_BANDS-1:0] base_q;
   logic [NUM_BANDS-1:0] wide_any;

   // primary plane: one flag per band; a mark in the same cycle beats a clear
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (invalidate) begin
         base_q <= '1;
      end else begin
         for (int i = 0; i < NUM_BANDS; i++) begin
            if (mark_en && mark_plane == PL_BASE && int'(mark_page) == i)
               base_q[i] <= 1'b1;
            else if (clr_en && int'(clr_lo) <= i && i <= int'(clr_hi))
               base_q[i] <= 1'b0;
         end
      end
   end

   generate
      if (HAS_WIDE) begin : g_wide
         localparam int NPG = 4 * NUM_BANDS;
         logic [NPG-1:0] deep_q;
         logic [NPG-1:0] ctrl_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               deep_q <= '0;
               ctrl_q <= '0;
            end else if (invalidate) begin
               deep_q <= '1;
               ctrl_q <= '1;
            end else begin
               for (int p = 0; p < NPG; p++) begin
                  if (mark_en && mark_plane == PL_DEEP && int'(mark_page) == p)
                     deep_q[p] <= 1'b1;
                  else if (clr_en && clr_wide && int'(clr_lo) <= (p >> 2)
                           && (p >> 2) <= int'(clr_hi))
                     deep_q[p] <= 1'b0;
                  if (mark_en && mark_plane == PL_CTRL && int'(mark_page) == p)
                     ctrl_q[p] <= 1'b1;
                  else if (clr_en && clr_wide && int'(clr_lo) <= (p >> 2)
                           && (p >> 2) <= int'(clr_hi))
                     ctrl_q[p] <= 1'b0;
               end
            end
         end

         for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
            assign wide_any[b] = (|deep_q[4*b +: 4]) | (|ctrl_q[4*b +: 4]);
         end
      end else begin : g_narrow
         assign wide_any = '0;
      end
   endgenerate

   assign band_dirty = base_q | (wide_mode ? wide_any : '0);
endmodule

// File: rtl/dbc_scan_ctrl.sv
module dbc_scan_ctrl
   import dbc_pkg::*;
#(
   parameter int NUM_BANDS = 192,
   parameter int WIDTH_W   = 11,
   parameter bit HAS_WIDE  = 1'b1,
   localparam int BCNT_W   = $clog2(NUM_BANDS + 1),
   localparam int LINE_W   = BCNT_W + 2,
   localparam int PAD_N    = 2 ** BCNT_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scan_start,
   input  logic                 cfg_wide,
   input  logic [LINE_W-1:0]    cfg_lines,
   input  logic [WIDTH_W-1:0]   cfg_width,
   input  logic [NUM_BANDS-1:0] band_dirty,
   input  logic                 rect_ready,
   output logic                 rect_valid,
   output logic [LINE_W-1:0]    rect_y,
   output logic [LINE_W-1:0]    rect_h,
   output logic [WIDTH_W-1:0]   rect_w,
   output logic                 scan_done,
   output logic                 wide_mode,
   output logic                 clr_en,
   output logic                 clr_wide,
   output logic [BCNT_W-1:0]    clr_lo,
   output logic [BCNT_W-1:0]    clr_hi
);
   scan_state_e       state_q;
   logic [BCNT_W-1:0] band_q, last_q, run_q, lo_q, hi_q;
   logic              open_q, seen_q, end_pend_q;

   logic [PAD_N-1:0]  dirty_pad;
   logic              at_end, cur_dirty;
   logic [LINE_W+1:0] lines_ext;
   logic [LINE_W+1:0] bands_raw;
   logic [BCNT_W-1:0] bands_cap;

   assign dirty_pad = PAD_N'(band_dirty);
   assign at_end    = (band_q == last_q);
   assign cur_dirty = !at_end && dirty_pad[band_q];

   // bands covering the active height, rounded up, never past the store
   assign lines_ext = {2'b00, cfg_lines} + (LINE_W+2)'(3);
   assign bands_raw = lines_ext >> 2;
   assign bands_cap = (int'(bands_raw) > NUM_BANDS) ? BCNT_W'(NUM_BANDS)
                                                     : BCNT_W'(bands_raw);

   assign clr_en   = (state_q == ST_CLEAR) && seen_q;
   assign clr_wide = wide_mode;
   assign clr_lo   = lo_q;
   assign clr_hi   = hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         band_q     <= '0;
         last_q     <= '0;
         run_q      <= '0;
         lo_q       <= '0;
         hi_q       <= '0;
         open_q     <= 1'b0;
         seen_q     <= 1'b0;
         end_pend_q <= 1'b0;
         wide_mode  <= 1'b0;
         rect_valid <= 1'b0;
         rect_y     <= '0;
         rect_h     <= '0;
         rect_w     <= '0;
         scan_done  <= 1'b0;
      end else begin
         scan_done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (scan_start) begin
                  state_q    <= ST_SCAN;
                  band_q     <= '0;
                  last_q     <= bands_cap;
                  open_q     <= 1'b0;
                  seen_q     <= 1'b0;
                  end_pend_q <= 1'b0;
                  wide_mode  <= cfg_wide & HAS_WIDE;
                  rect_w     <= cfg_width;
               end
            end
            ST_SCAN: begin
               if (cur_dirty) begin
                  if (!open_q) begin
                     open_q <= 1'b1;
                     run_q  <= band_q;
                  end
                  if (!seen_q) lo_q <= band_q;
                  seen_q <= 1'b1;
                  hi_q   <= band_q;
                  band_q <= band_q + 1'b1;
               end else if (open_q) begin
                  rect_valid <= 1'b1;
                  rect_y     <= {run_q, 2'b00};
                  rect_h     <= {band_q - run_q, 2'b00};
                  open_q     <= 1'b0;
                  end_pend_q <= at_end;
                  if (!at_end) band_q <= band_q + 1'b1;
                  state_q    <= ST_HOLD;
               end else if (at_end) begin
                  state_q <= ST_CLEAR;
               end else begin
                  band_q <= band_q + 1'b1;
               end
            end
            ST_HOLD: begin
               if (rect_ready) begin
                  rect_valid <= 1'b0;
                  state_q    <= end_pend_q ? ST_CLEAR : ST_SCAN;
               end
            end
            ST_CLEAR: begin
               scan_done <= 1'b1;
               state_q   <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dirty_band_coalescer.sv
module dirty_band_coalescer
   import dbc_pkg::*;
#(
   parameter int NUM_BANDS = 192,
   parameter int WIDTH_W   = 11,
   parameter bit HAS_WIDE  = 1'b1,
   localparam int BCNT_W   = $clog2(NUM_BANDS + 1),
   localparam int LINE_W   = BCNT_W + 2,
   localparam int PAGE_W   = BCNT_W + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mark_en,
   input  logic [1:0]         mark_plane,
   input  logic [PAGE_W-1:0]  mark_page,
   input  logic               invalidate,
   input  logic               scan_start,
   input  logic               cfg_wide,
   input  logic [LINE_W-1:0]  cfg_lines,
   input  logic [WIDTH_W-1:0] cfg_width,
   output logic               rect_valid,
   input  logic               rect_ready,
   output logic [LINE_W-1:0]  rect_y,
   output logic [LINE_W-1:0]  rect_h,
   output logic [WIDTH_W-1:0] rect_w,
   output logic               scan_done
);
   generate
      if (NUM_BANDS < 2) begin : g_bad_bands
         $error("dirty_band_coalescer: NUM_BANDS must be at least 2");
      end
      if (WIDTH_W < 1) begin : g_bad_width
         $error("dirty_band_coalescer: WIDTH_W must be at least 1");
      end
   endgenerate

   logic [NUM_BANDS-1:0] band_dirty;
   logic                 wide_mode, clr_en, clr_wide;
   logic [BCNT_W-1:0]    clr_lo, clr_hi;

   dbc_dirty_store #(
      .NUM_BANDS (NUM_BANDS),
      .HAS_WIDE  (HAS_WIDE)
   ) i_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .mark_en    (mark_en),
      .mark_plane (mark_plane),
      .mark_page  (mark_page),
      .invalidate (invalidate),
      .clr_en     (clr_en),
      .clr_wide   (clr_wide),
      .clr_lo     (clr_lo),
      .clr_hi     (clr_hi),
      .wide_mode  (wide_mode),
      .band_dirty (band_dirty)
   );

   dbc_scan_ctrl #(
      .NUM_BANDS (NUM_BANDS),
      .WIDTH_W   (WIDTH_W),
      .HAS_WIDE  (HAS_WIDE)
   ) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .scan_start (scan_start),
      .cfg_wide   (cfg_wide),
      .cfg_lines  (cfg_lines),
      .cfg_width  (cfg_width),
      .band_dirty (band_dirty),
      .rect_ready (rect_ready),
      .rect_valid (rect_valid),
      .rect_y     (rect_y),
      .rect_h     (rect_h),
      .rect_w     (rect_w),
      .scan_done  (scan_done),
      .wide_mode  (wide_mode),
      .clr_en     (clr_en),
      .clr_wide   (clr_wide),
      .clr_lo     (clr_lo),
      .clr_hi     (clr_hi)
   );
endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
   parameter int NUM_BANDS = 192,
   parameter int LINE_W    = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rect_valid,
   input logic              rect_ready,
   input logic [LINE_W-1:0] rect_y,
   input logic [LINE_W-1:0] rect_h,
   input logic              scan_done
);
   AST_RECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rect_valid && !rect_ready |=> rect_valid && $stable(rect_y) && $stable(rect_h)); // R11

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |=> !scan_done); // R9

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> !rect_valid); // R9

   AST_RECT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      rect_valid |-> rect_h != '0 && rect_y[1:0] == 2'b00 && rect_h[1:0] == 2'b00); // R3

   AST_RECT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rect_valid |-> ({1'b0, rect_y} + {1'b0, rect_h}) <= (LINE_W+1)'(4 * NUM_BANDS)); // R4
endmodule

bind dirty_band_coalescer dbc_checker #(
   .NUM_BANDS (NUM_BANDS),
   .LINE_W    (LINE_W)
) i_dbc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .rect_valid (rect_valid),
   .rect_ready (rect_ready),
   .rect_y     (rect_y),
   .rect_h     (rect_h),
   .scan_done  (scan_done)
);

// File: tb/test_dirty_band_coalescer.sv
`timescale 1ns/1ps
module test_dirty_band_coalescer;
   localparam int NB = 8;
   localparam int WW = 11;
   localparam int LW = $clog2(NB + 1) + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mark_en = 1'b0;
   logic [1:0]    mark_plane = '0;
   logic [LW-1:0] mark_page = '0;
   logic          invalidate = 1'b0;
   logic          scan_start = 1'b0;
   logic          cfg_wide = 1'b0;
   logic [LW-1:0] cfg_lines = '0;
   logic [WW-1:0] cfg_width = '0;
   logic          rect_valid;
   logic          rect_ready = 1'b1;
   logic [LW-1:0] rect_y, rect_h;
   logic [WW-1:0] rect_w;
   logic          scan_done;

   int n_tests = 0;
   int n_fail  = 0;
   bit stall   = 0;
   int tick    = 0;
   int cyc     = 0;

   int cap_n = 0, cap_y[16], cap_h[16], cap_w[16];
   int done_n = 0;
   int exp_n = 0, exp_y[16], exp_h[16];

   always #2.5 clk = ~clk;

   dirty_band_coalescer #(.NUM_BANDS(NB), .WIDTH_W(WW), .HAS_WIDE(1'b1)) i_dirty_band_coalescer (
      .clk(clk), .rst_n(rst_n), .mark_en(mark_en), .mark_plane(mark_plane),
      .mark_page(mark_page), .invalidate(invalidate), .scan_start(scan_start),
      .cfg_wide(cfg_wide), .cfg_lines(cfg_lines), .cfg_width(cfg_width),
      .rect_valid(rect_valid), .rect_ready(rect_ready), .rect_y(rect_y),
      .rect_h(rect_h), .rect_w(rect_w), .scan_done(scan_done));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rect_valid && rect_ready && cap_n < 16) begin
         cap_y[cap_n] = int'(rect_y);
         cap_h[cap_n] = int'(rect_h);
         cap_w[cap_n] = int'(rect_w);
         cap_n = cap_n + 1;
      end
      if (scan_done) done_n = done_n + 1;
   end

   always @(negedge clk) begin
      tick <= tick + 1;
      rect_ready <= stall ? (tick % 3 == 2) : 1'b1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic mark(input int plane, input int page);
      @(negedge clk);
      mark_en = 1'b1; mark_plane = 2'(plane); mark_page = LW'(page);
      @(negedge clk);
      mark_en = 1'b0;
   endtask

   task automatic want(input int y, input int h);
      exp_y[exp_n] = y; exp_h[exp_n] = h; exp_n++;
   endtask

   // runs one scan and compares the accepted rectangles with the expectation list
   task automatic run_scan(input bit wide, input int lines, input int width, input string req);
      int guard;
      @(negedge clk);
      cap_n = 0; done_n = 0;
      cfg_wide = wide; cfg_lines = LW'(lines); cfg_width = WW'(width);
      scan_start = 1'b1;
      @(negedge clk);
      scan_start = 1'b0;
      guard = 0;
      while (done_n == 0 && guard < 400) begin
         @(negedge clk);
         guard++;
      end
      repeat (3) @(negedge clk);
      chk(done_n == 1, {req, " R9 done pulse count"}, done_n, 1);
      chk(cap_n == exp_n, {req, " rect count"}, cap_n, exp_n);
      for (int k = 0; k < exp_n && k < cap_n; k++) begin
         chk(cap_y[k] == exp_y[k], {req, " R2 rect_y"}, cap_y[k], exp_y[k]);
         chk(cap_h[k] == exp_h[k], {req, " R3 rect_h"}, cap_h[k], exp_h[k]);
         chk(cap_w[k] == width, {req, " R5 rect_w"}, cap_w[k], width);
      end
      exp_n = 0;
   endtask

   task automatic t_reset;
      chk(rect_valid == 1'b0, "R1 rect_valid after reset", int'(rect_valid), 0);
      chk(scan_done == 1'b0, "R1 scan_done after reset", int'(scan_done), 0);
      run_scan(1'b1, 32, 640, "R1 clean after reset");
   endtask

   task automatic t_single;
      mark(0, 3);
      want(12, 4);
      run_scan(1'b0, 32, 640, "R2 single band");
   endtask

   task automatic t_merge;
      mark(0, 1); mark(0, 2); mark(0, 3); mark(0, 5);
      want(4, 12); want(20, 4);
      run_scan(1'b0, 32, 1024, "R3 merge runs");
      run_scan(1'b0, 32, 1024, "R8 cleared after merge");
   endtask

   task automatic t_tail;
      mark(0, 6); mark(0, 7);
      want(24, 8);
      run_scan(1'b0, 30, 800, "R4 tail flush");
   endtask

   task automatic t_trunc;
      mark(0, 5);
      run_scan(1'b0, 16, 800, "R4 band beyond height");
      want(20, 4);
      run_scan(1'b0, 32, 800, "R8 unscanned band kept");
      run_scan(1'b0, 32, 800, "R9 empty scan");
   endtask

   task automatic t_wide;
      mark(1, 9); mark(2, 23);
      run_scan(1'b0, 32, 512, "R7 narrow ignores extra planes");
      want(8, 4); want(20, 4);
      run_scan(1'b1, 32, 512, "R7 wide sees extra planes");
      run_scan(1'b1, 32, 512, "R8 wide clears extra planes");
   endtask

   task automatic t_plane_clear;
      mark(0, 2); mark(1, 8);
      want(8, 4);
      run_scan(1'b0, 32, 300, "R8 narrow scan clears primary");
      want(8, 4);
      run_scan(1'b1, 32, 300, "R8 extra plane survived narrow clear");
      run_scan(1'b1, 32, 300, "R8 all clean");
   endtask

   task automatic t_ignore;
      mark(3, 2);
      run_scan(1'b1, 32, 300, "R6 plane code 3 ignored");
   endtask

   task automatic t_inval;
      @(negedge clk); invalidate = 1'b1;
      @(negedge clk); invalidate = 1'b0;
      want(0, 32);
      run_scan(1'b1, 32, 1024, "R10 invalidate full redraw");
      run_scan(1'b1, 32, 1024, "R10 cleared after redraw");
   endtask

   task automatic t_stall;
      stall = 1;
      mark(0, 0); mark(0, 2); mark(0, 4); mark(2, 27);
      want(0, 4); want(8, 4); want(16, 4); want(24, 4);
      run_scan(1'b1, 32, 700, "R11 stalled handshake");
      stall = 0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_single;
      t_merge;
      t_tail;
      t_trunc;
      t_wide;
      t_plane_clear;
      t_ignore;
      t_inval;
      t_stall;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      wait (cyc > 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule